// File: doc/BRIEF.md
# Serial Command and Readback Port

This block is the digital front end of a multichannel track-and-hold controller. A host drives an active-low frame line, a serial clock and a data line. A data-out line is tri-stated, and the block models it as a data bit plus an output enable. The system clock oversamples all pins through synchronizers. Each write frame carries a ten-bit command, MSB first. The command asks the acquisition sequencer to acquire a channel, to acquire and then report the channel's register, or only to report the register.

For a command that asks for readback, the frame after it becomes a read frame. In that frame the block fetches the addressed fourteen-bit register through a combinational read port and shifts it out MSB first. In acquire-then-readback mode the shifting waits until the sequencer's busy signal has dropped. Commands with an illegal mode or with the test bit set are not executed, and they latch an error flag.

Top module: `scp_port`

## Requirements
- R1: After reset, sdo_oe, acq_req and cmd_err are all 0.
- R2: A write frame captures sdi on falling sclk edges after frame_n falls, MSB first. Command bits [9:8] are the mode, [7] calibrate, [6] offset select, [5] test and [4:0] the channel. Mode 00 (acquire) and mode 10 (acquire then read) issue exactly one acq_req pulse after the tenth bit, carrying acq_cal, acq_ofs and acq_chan.
- R3: With offset select set, the channel field is ignored. acq_chan reads 0, and the readback address is 32.
- R4: Mode 01 or a set test bit sets cmd_err, which stays set until reset. No request is issued and no read frame follows.
- R5: A frame whose frame_n rises before the tenth falling sclk edge has no effect.
- R6: Serial clocks after the tenth bit of a frame are ignored, and no second request is issued.
- R7: After a mode 10 or 11 command, the next frame is a read frame. sdo_oe rises on its first rising sclk edge, and sdo presents bit 13 of the register at rd_addr (the channel, or 32 for offset). Each following rising edge presents the next lower bit.
- R8: sdo_oe falls on the fourteenth falling sclk edge of a read frame. Later clocks leave it low, and sdi has no effect in a read frame.
- R9: In a read frame, rising sclk edges that arrive while acq_busy is high are ignored. Shifting begins on the first rising edge after acq_busy is low.
- R10: If frame_n rises during a read frame, sdo_oe drops. The readback stays pending, and the next frame repeats the whole word.
- R11: Mode 11 (read only) issues no acq_req.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the serial pins |
| rst | input | 1 | Synchronous active-high reset |
| frame_n | input | 1 | Active-low frame |
| sclk | input | 1 | Serial clock, idle low |
| sdi | input | 1 | Serial command data |
| sdo | output | 1 | Serial readback data |
| sdo_oe | output | 1 | Drive enable for sdo (0 = high impedance) |
| acq_req | output | 1 | One-cycle acquire request to the sequencer |
| acq_cal | output | 1 | Request targets all channels at once |
| acq_ofs | output | 1 | Request targets the offset channel |
| acq_chan | output | 5 | Requested channel |
| acq_busy | input | 1 | Sequencer acquisition in progress |
| rd_addr | output | 6 | Register index for readback (32 = offset) |
| rd_data | input | 14 | Register contents at rd_addr |
| cmd_err | output | 1 | Sticky illegal-command flag |

## Verification
A bit counter in the wrong state shows up as a missing, doubled or misplaced acq_req pulse within a few system clocks of the tenth serial edge. It can also show as a channel field shifted by one bit. A wrong pending-read flag turns the following frame into the wrong type, so an acquire is lost or sdo_oe rises when no read was asked for. A fault in the readback shifter appears on sdo at the first rising edge where the word differs from the one computed for the addressed register. An enable that is released late is seen at the fourteenth falling edge.

// File: rtl/scp_pkg.sv
package scp_pkg;

    localparam int CH_W    = 5;
    localparam int RB_W    = 14;
    localparam int MODE_W  = 2;
    localparam int CMD_W   = MODE_W + 3 + CH_W;
    localparam int RA_W    = CH_W + 1;
    localparam int OFS_IDX = 1 << CH_W;

    typedef enum logic [MODE_W-1:0] {
        M_ACQ    = 2'b00,
        M_BAD    = 2'b01,
        M_ACQ_RB = 2'b10,
        M_RB     = 2'b11
    } mode_e;

    typedef struct packed {
        mode_e           mode;
        logic            cal;
        logic            ofs;
        logic            test;
        logic [CH_W-1:0] chan;
    } cmd_t;

    function automatic logic cmd_bad(cmd_t c);
        return (c.mode == M_BAD) || c.test;
    endfunction

    function automatic logic cmd_acq(cmd_t c);
        return (c.mode == M_ACQ) || (c.mode == M_ACQ_RB);
    endfunction

    function automatic logic cmd_rb(cmd_t c);
        return (c.mode == M_ACQ_RB) || (c.mode == M_RB);
    endfunction

    function automatic logic [RA_W-1:0] rb_index(cmd_t c);
        return c.ofs ? RA_W'(OFS_IDX) : {1'b0, c.chan};
    endfunction

endpackage

// File: rtl/scp_sync.sv
module scp_sync #(
    parameter int W     = 1,
    parameter int DEPTH = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] stg [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) stg[i] <= RST_VAL;
        end else begin
            stg[0] <= din;
            for (int i = 1; i < DEPTH; i++) stg[i] <= stg[i-1];
        end
    end

    assign dout = stg[DEPTH-1];
endmodule

// File: rtl/scp_rx.sv
module scp_rx
    import scp_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic active,
    input  logic en,
    input  logic fall,
    input  logic sdi,
    output logic cmd_vld,
    output cmd_t cmd
);
    localparam int CNT_W = $clog2(CMD_W + 1);

    logic [CMD_W-1:0] sh;
    logic [CNT_W-1:0] cnt;
    logic             done;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh      <= '0;
            cnt     <= '0;
            done    <= 1'b0;
            cmd_vld <= 1'b0;
        end else begin
            cmd_vld <= 1'b0;
            if (start) begin
                cnt  <= '0;
                done <= 1'b0;
            end else if (active && en && fall && !done) begin
                sh  <= {sh[CMD_W-2:0], sdi};
                cnt <= cnt + 1'b1;
                if (cnt == CNT_W'(CMD_W - 1)) begin
                    done    <= 1'b1;
                    cmd_vld <= 1'b1;
                end
            end
        end
    end

    assign cmd = cmd_t'(sh);
endmodule

// File: rtl/scp_tx.sv
module scp_tx
    import scp_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            start,
    input  logic            active,
    input  logic            en,
    input  logic            rise,
    input  logic            fall,
    input  logic            busy,
    input  logic [RB_W-1:0] rd_data,
    output logic            sdo,
    output logic            sdo_oe,
    output logic            fin_p
);
    localparam int CNT_W = $clog2(RB_W + 1);

    logic [RB_W-1:0]  sh;
    logic [CNT_W-1:0] cnt;
    logic             started;
    logic             fin;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh      <= '0;
            cnt     <= '0;
            started <= 1'b0;
            fin     <= 1'b0;
            sdo_oe  <= 1'b0;
            fin_p   <= 1'b0;
        end else begin
            fin_p <= 1'b0;
            if (start) begin
                cnt     <= '0;
                started <= 1'b0;
                fin     <= 1'b0;
                sdo_oe  <= 1'b0;
            end else if (!active) begin
                sdo_oe <= 1'b0;
            end else if (en && !fin) begin
                if (rise) begin
                    if (!started) begin
                        if (!busy) begin
                            sh      <= rd_data;
                            started <= 1'b1;
                            sdo_oe  <= 1'b1;
                        end
                    end else begin
                        sh <= {sh[RB_W-2:0], 1'b0};
                    end
                end
                if (fall && started) begin
                    cnt <= cnt + 1'b1;
                    if (cnt == CNT_W'(RB_W - 1)) begin
                        fin    <= 1'b1;
                        sdo_oe <= 1'b0;
                        fin_p  <= 1'b1;
                    end
                end
            end
        end
    end

    assign sdo = sh[RB_W-1];
endmodule

// File: rtl/scp_port.sv
module scp_port
    import scp_pkg::*;
#(
    parameter int SYNC_DEPTH = 2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            frame_n,
    input  logic            sclk,
    input  logic            sdi,
    output logic            sdo,
    output logic            sdo_oe,
    output logic            acq_req,
    output logic            acq_cal,
    output logic            acq_ofs,
    output logic [CH_W-1:0] acq_chan,
    input  logic            acq_busy,
    output logic [RA_W-1:0] rd_addr,
    input  logic [RB_W-1:0] rd_data,
    output logic            cmd_err
);
    logic [2:0] pin_s;
    logic       frm_s, clk_s, dat_s;
    logic       frm_q, clk_q;
    logic       frm_fall, frm_rise, sck_rise, sck_fall;
    logic       frm_act, rd_frm, rb_pend;
    logic       cmd_vld, tx_fin;
    cmd_t       cmd;

    scp_sync #(.W(3), .DEPTH(SYNC_DEPTH), .RST_VAL(3'b100)) u_sync (
        .clk (clk),
        .rst (rst),
        .din ({frame_n, sclk, sdi}),
        .dout(pin_s)
    );

    assign {frm_s, clk_s, dat_s} = pin_s;

    always_ff @(posedge clk) begin
        if (rst) begin
            frm_q <= 1'b1;
            clk_q <= 1'b0;
        end else begin
            frm_q <= frm_s;
            clk_q <= clk_s;
        end
    end

    assign frm_fall = frm_q & ~frm_s;
    assign frm_rise = ~frm_q & frm_s;
    assign sck_rise = ~clk_q & clk_s;
    assign sck_fall = clk_q & ~clk_s;

    always_ff @(posedge clk) begin
        if (rst) begin
            frm_act <= 1'b0;
            rd_frm  <= 1'b0;
        end else if (frm_fall) begin
            frm_act <= 1'b1;
            rd_frm  <= rb_pend;
        end else if (frm_rise) begin
            frm_act <= 1'b0;
        end
    end

    scp_rx u_rx (
        .clk    (clk),
        .rst    (rst),
        .start  (frm_fall),
        .active (frm_act),
        .en     (!rd_frm),
        .fall   (sck_fall),
        .sdi    (dat_s),
        .cmd_vld(cmd_vld),
        .cmd    (cmd)
    );

    scp_tx u_tx (
        .clk    (clk),
        .rst    (rst),
        .start  (frm_fall),
        .active (frm_act),
        .en     (rd_frm),
        .rise   (sck_rise),
        .fall   (sck_fall),
        .busy   (acq_busy),
        .rd_data(rd_data),
        .sdo    (sdo),
        .sdo_oe (sdo_oe),
        .fin_p  (tx_fin)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            acq_req  <= 1'b0;
            acq_cal  <= 1'b0;
            acq_ofs  <= 1'b0;
            acq_chan <= '0;
            rb_pend  <= 1'b0;
            rd_addr  <= '0;
            cmd_err  <= 1'b0;
        end else begin
            acq_req <= 1'b0;
            if (tx_fin) rb_pend <= 1'b0;
            if (cmd_vld) begin
                if (cmd_bad(cmd)) begin
                    cmd_err <= 1'b1;
                end else begin
                    if (cmd_acq(cmd)) begin
                        acq_req  <= 1'b1;
                        acq_cal  <= cmd.cal;
                        acq_ofs  <= cmd.ofs;
                        acq_chan <= cmd.ofs ? '0 : cmd.chan;
                    end
                    if (cmd_rb(cmd)) begin
                        rb_pend <= 1'b1;
                        rd_addr <= rb_index(cmd);
                    end
                end
            end
        end
    end
endmodule

// File: rtl/scp_port_chk.sv
module scp_port_chk (
    input logic clk,
    input logic rst,
    input logic acq_req,
    input logic acq_busy,
    input logic sdo_oe,
    input logic cmd_err,
    input logic frm_act,
    input logic rd_frm
);
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
        cmd_err |=> cmd_err); // R4
    AST_NO_REQ_ON_ERR: assert property (@(posedge clk) disable iff (rst)
        $rose(cmd_err) |-> !acq_req); // R4
    AST_REQ_SINGLE: assert property (@(posedge clk) disable iff (rst)
        acq_req |=> !acq_req); // R6
    AST_OE_READ_FRAME: assert property (@(posedge clk) disable iff (rst)
        sdo_oe |-> rd_frm); // R7
    AST_OE_DROP_ABORT: assert property (@(posedge clk) disable iff (rst)
        $fell(frm_act) |=> !sdo_oe); // R10
    AST_OE_NOT_BUSY: assert property (@(posedge clk) disable iff (rst)
        $rose(sdo_oe) |-> !$past(acq_busy)); // R9
endmodule

bind scp_port scp_port_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .acq_req (acq_req),
    .acq_busy(acq_busy),
    .sdo_oe  (sdo_oe),
    .cmd_err (cmd_err),
    .frm_act (frm_act),
    .rd_frm  (rd_frm)
);

// File: tb/scp_port_test.sv
module scp_port_test;
    localparam int CLK_PER = 10;
    localparam int HB      = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        frame_n = 1'b1;
    logic        sclk = 1'b0;
    logic        sdi = 1'b0;
    logic        sdo, sdo_oe, acq_req, acq_cal, acq_ofs, cmd_err;
    logic [4:0]  acq_chan;
    logic        acq_busy = 1'b0;
    logic [5:0]  rd_addr;
    logic [13:0] rd_data;

    typedef struct { logic cal; logic ofs; logic [4:0] chan; } exp_t;
    exp_t exp_q[$];
    int   checks = 0;
    int   errors = 0;
    int   busy_len = 6;
    int   busy_cnt = 0;
    bit   reported = 0;

    always #(CLK_PER/2) clk = ~clk;

    function automatic logic [13:0] regval(logic [5:0] a);
        return 14'((int'(a) * 397 + 419) % 16384);
    endfunction

    assign rd_data = regval(rd_addr);

    scp_port uut (
        .clk(clk), .rst(rst), .frame_n(frame_n), .sclk(sclk), .sdi(sdi),
        .sdo(sdo), .sdo_oe(sdo_oe), .acq_req(acq_req), .acq_cal(acq_cal),
        .acq_ofs(acq_ofs), .acq_chan(acq_chan), .acq_busy(acq_busy),
        .rd_addr(rd_addr), .rd_data(rd_data), .cmd_err(cmd_err)
    );

    task automatic chk(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic report();
        if (!reported) begin
            reported = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    function automatic logic [9:0] mk(logic [1:0] m, logic c, logic o, logic t, logic [4:0] ch);
        return {m, c, o, t, ch};
    endfunction

    task automatic push(logic c, logic o, logic [4:0] ch);
        exp_t e;
        e.cal = c; e.ofs = o; e.chan = ch;
        exp_q.push_back(e);
    endtask

    task automatic wr_frame(logic [9:0] w, int nbits, int extra);
        frame_n = 1'b0;
        tick(HB);
        for (int i = 0; i < nbits + extra; i++) begin
            sdi  = (i < nbits) ? w[9-i] : 1'b1;
            sclk = 1'b1;
            tick(HB);
            sclk = 1'b0;
            tick(HB);
        end
        frame_n = 1'b1;
        tick(2*HB);
    endtask

    task automatic rd_frame(logic [5:0] addr, int n_early, int n_extra);
        logic [13:0] d;
        d = regval(addr);
        frame_n = 1'b0;
        tick(HB);
        for (int i = 0; i < n_early; i++) begin
            sclk = 1'b1; sdi = i[0];
            tick(6);
            chk(sdo_oe == 1'b0, "R9", "oe while busy", int'(sdo_oe), 0);
            tick(HB-6);
            sclk = 1'b0;
            tick(HB);
        end
        while (acq_busy) tick(1);
        tick(2);
        for (int i = 0; i < 14 + n_extra; i++) begin
            sclk = 1'b1; sdi = ~i[0];
            tick(6);
            if (i < 14) begin
                chk(sdo_oe == 1'b1, "R7", "oe during word", int'(sdo_oe), 1);
                chk(sdo == d[13-i], "R7", "sdo bit", int'(sdo), int'(d[13-i]));
            end else begin
                chk(sdo_oe == 1'b0, "R8", "oe after word", int'(sdo_oe), 0);
            end
            tick(HB-6);
            sclk = 1'b0;
            tick(HB);
            if (i == 13) chk(sdo_oe == 1'b0, "R8", "oe at 14th fall", int'(sdo_oe), 0);
        end
        frame_n = 1'b1;
        tick(2*HB);
    endtask

    // monitor: scoreboard and sequencer busy model
    initial begin
        forever begin
            @(negedge clk);
            if (acq_req) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R2", "unexpected acq_req", 1, 0);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    chk(acq_cal == e.cal, "R2", "acq_cal", int'(acq_cal), int'(e.cal));
                    chk(acq_ofs == e.ofs, "R3", "acq_ofs", int'(acq_ofs), int'(e.ofs));
                    chk(acq_chan == e.chan, "R2", "acq_chan", int'(acq_chan), int'(e.chan));
                end
                busy_cnt = busy_len;
            end
            acq_busy = (busy_cnt > 0);
            if (busy_cnt > 0) busy_cnt--;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        chk(1'b0, "WDOG", "watchdog expired", 0, 1);
        report();
    end

    initial begin
        tick(5);
        rst = 1'b0;
        tick(2);
        chk(sdo_oe == 1'b0, "R1", "reset oe", int'(sdo_oe), 0);
        chk(acq_req == 1'b0, "R1", "reset req", int'(acq_req), 0);
        chk(cmd_err == 1'b0, "R1", "reset err", int'(cmd_err), 0);

        // R2 basic acquires
        push(0, 0, 5'd5);  wr_frame(mk(2'b00, 0, 0, 0, 5'd5), 10, 0);
        push(1, 0, 5'd31); wr_frame(mk(2'b00, 1, 0, 0, 5'd31), 10, 0);
        // R3 offset select masks the channel
        push(0, 1, 5'd0);  wr_frame(mk(2'b00, 0, 1, 0, 5'd13), 10, 0);
        // R11 read-only, R7/R8 read frame with surplus clocks
        wr_frame(mk(2'b11, 0, 0, 0, 5'd9), 10, 0);
        chk(exp_q.size() == 0, "R11", "no request for read-only", exp_q.size(), 0);
        rd_frame(6'd9, 0, 3);
        // R2/R7 acquire then read, short busy
        push(0, 0, 5'd20); wr_frame(mk(2'b10, 0, 0, 0, 5'd20), 10, 0);
        rd_frame(6'd20, 0, 0);
        // R3 offset readback index 32
        wr_frame(mk(2'b11, 0, 1, 0, 5'd7), 10, 0);
        rd_frame(6'd32, 0, 0);
        // R5 short frame discarded
        wr_frame(mk(2'b00, 0, 0, 0, 5'd3), 6, 0);
        chk(exp_q.size() == 0, "R5", "short frame queue", exp_q.size(), 0);
        chk(cmd_err == 1'b0, "R5", "short frame err", int'(cmd_err), 0);
        // R6 surplus clocks ignored
        push(0, 0, 5'd17); wr_frame(mk(2'b00, 0, 0, 0, 5'd17), 10, 5);
        // R10 aborted read frame stays pending
        wr_frame(mk(2'b11, 0, 0, 0, 5'd2), 10, 0);
        frame_n = 1'b0;
        tick(HB);
        for (int i = 0; i < 3; i++) begin
            sclk = 1'b1; tick(HB); sclk = 1'b0; tick(HB);
        end
        chk(sdo_oe == 1'b1, "R10", "oe before abort", int'(sdo_oe), 1);
        frame_n = 1'b1;
        tick(6);
        chk(sdo_oe == 1'b0, "R10", "oe after abort", int'(sdo_oe), 0);
        tick(2*HB);
        rd_frame(6'd2, 0, 0);
        // R9 long busy holds off shifting
        busy_len = 100;
        push(0, 0, 5'd11); wr_frame(mk(2'b10, 0, 0, 0, 5'd11), 10, 0);
        rd_frame(6'd11, 3, 0);
        busy_len = 6;
        // R4 illegal mode and test bit
        wr_frame(mk(2'b01, 0, 0, 0, 5'd4), 10, 0);
        chk(cmd_err == 1'b1, "R4", "err after mode 01", int'(cmd_err), 1);
        wr_frame(mk(2'b10, 0, 0, 1, 5'd8), 10, 0);
        chk(exp_q.size() == 0, "R4", "no request on test bit", exp_q.size(), 0);
        push(0, 0, 5'd6); wr_frame(mk(2'b00, 0, 0, 0, 5'd6), 10, 0);
        chk(cmd_err == 1'b1, "R4", "err sticky", int'(cmd_err), 1);

        tick(20);
        chk(exp_q.size() == 0, "R2", "all requests seen", exp_q.size(), 0);
        report();
    end
endmodule